// File: doc/BRIEF.md
# CAN Protocol Status Register

This block is the protocol status word of a CAN FD controller. The host reads it over a simple register bus. The protocol engine feeds it single-cycle event strobes:

- a frame finished cleanly;
- an error was found, together with its type;
- an FD frame was received, together with its bit-rate-switch and error-state-indicator bits;
- a protocol exception occurred.

The engine also supplies level inputs for the node's activity, its fault-confinement state and the measured transmitter delay value.

Error results go to one of two 3-bit codes. An event that ends a bit-rate-switched FD frame after it has entered its data phase updates the data-phase code. Every other event updates the arbitration-phase code. When the host reads the register, the arbitration-phase code is reloaded to the "no change" value 7. The host can therefore tell whether anything happened on the bus between two reads. The exception flag and the received-FD flags are read-to-clear. A new event in the same cycle as the read is kept.

The `rd_data` output shows the current contents at all times. Asserting `host_rd` marks a read access, and its side effects take effect at the next clock edge.

Top module: `can_psr`

## Requirements
- R1: An error strobe outside the data phase stores its 3-bit type in rd_data[2:0] on the next cycle, with the encoding 0 none, 1 stuff, 2 form, 3 ack, 4 bit1, 5 bit0, 6 CRC, 7 no change.
- R2: After synchronous reset, rd_data[2:0] and rd_data[10:8] both read 7 and flag bits 14:11 read 0.
- R3: A host read reloads rd_data[2:0] to 7 on the next cycle and leaves rd_data[10:8] unchanged.
- R4: A clean-frame strobe outside the data phase sets rd_data[2:0] to 0.
- R5: An error or clean-frame event with the data-phase input high updates rd_data[10:8] instead (0 for a clean frame), and rd_data[2:0] keeps its value.
- R6: A stuff error flagged as lying on a fixed stuff bit of an FD CRC sequence is stored as form error (2).
- R7: An FD receive strobe sets bit 13 and copies its BRS and ESI inputs into bits 12 and 11.
- R8: Bits 4:3 show the activity input (00 synchronizing, 01 idle, 10 receiver, 11 transmitter), and bits 7, 6 and 5 show bus-off, warning and error-passive.
- R9: Bits 22:16 show the 7-bit delay value, and bits 31:23 and 15 read 0.
- R10: A protocol exception strobe sets bit 14. A host read clears bits 14:11, unless a set event for that bit arrives in the same cycle, in which case the event wins.
- R11: An error strobe in the same cycle as a host read stores the error code rather than 7.
- R12: If the error and clean-frame strobes coincide, the error code is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_rd | input | 1 | Host read access of the register |
| rd_data | output | 32 | Register contents |
| frame_ok | input | 1 | Frame sent or received without error |
| err_evt | input | 1 | Error detected |
| err_type | input | 3 | Error type code (1..6) |
| in_data_phase | input | 1 | Current event ends a BRS FD frame in its data phase |
| crc_fixed_stuff | input | 1 | Stuff error lies on a fixed stuff bit of the FD CRC |
| fd_rx | input | 1 | FD frame received |
| fd_rx_brs | input | 1 | BRS bit of that frame |
| fd_rx_esi | input | 1 | ESI bit of that frame |
| proto_exc | input | 1 | Protocol exception event |
| activity | input | 2 | Node activity state |
| bus_off | input | 1 | Bus-off state |
| err_warn | input | 1 | Error warning state |
| err_passive | input | 1 | Error passive state |
| tdc_value | input | 7 | Transmitter delay compensation value |

## Verification
The assertions assume that every strobe is a single-cycle pulse and that `err_type` carries a real error type (1 to 6) whenever `err_evt` is high. They also assume that `crc_fixed_stuff` and `in_data_phase` are meaningful only alongside an event strobe. The directed stimulus raises each strobe for exactly one cycle, with legal type codes, and drops every qualifier back to zero afterwards. Coincidences such as a read together with an error, or an error together with a clean frame, are created on purpose in single cycles.

// File: rtl/can_psr_pkg.sv
package can_psr_pkg;

    localparam int REG_W     = 32;
    localparam int CODE_W    = 3;
    localparam int TDC_W     = 7;
    localparam int ACT_W     = 2;
    localparam int HI_RSVD_W = REG_W - TDC_W - 16;

    // sticky flag indices
    localparam int NUM_FLAGS = 4;
    localparam int FL_RESI   = 0;
    localparam int FL_RBRS   = 1;
    localparam int FL_RFDF   = 2;
    localparam int FL_PXE    = 3;

    typedef enum logic [CODE_W-1:0] {
        ERR_NONE  = 3'd0,
        ERR_STUFF = 3'd1,
        ERR_FORM  = 3'd2,
        ERR_ACK   = 3'd3,
        ERR_BIT1  = 3'd4,
        ERR_BIT0  = 3'd5,
        ERR_CRC   = 3'd6,
        ERR_NOCHG = 3'd7
    } err_code_e;

    typedef enum logic [ACT_W-1:0] {
        ACT_SYNC = 2'd0,
        ACT_IDLE = 2'd1,
        ACT_RX   = 2'd2,
        ACT_TX   = 2'd3
    } act_e;

    typedef struct packed {
        logic [HI_RSVD_W-1:0] rsvd_hi;
        logic [TDC_W-1:0]     tdc;
        logic                 rsvd15;
        logic [NUM_FLAGS-1:0] flags;
        err_code_e            dlec;
        logic                 bo;
        logic                 ew;
        logic                 ep;
        act_e                 act;
        err_code_e            lec;
    } psr_t;

    // fixed stuff bits in an FD CRC are format elements: report as form
    function automatic err_code_e classify(input logic [CODE_W-1:0] raw,
                                           input logic fixed_stuff);
        err_code_e c;
        c = err_code_e'(raw);
        if (c == ERR_STUFF && fixed_stuff)
            c = ERR_FORM;
        return c;
    endfunction

endpackage

// File: rtl/can_psr_errlog.sv
module can_psr_errlog
    import can_psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd,
    input  logic              ok,
    input  logic              err,
    input  logic [CODE_W-1:0] err_code,
    input  logic              dphase,
    input  logic              fixed_stuff,
    output err_code_e         lec,
    output err_code_e         dlec
);

    logic      ev;
    err_code_e ev_code;

    always_comb begin
        ev      = err | ok;
        ev_code = err ? classify(err_code, fixed_stuff) : ERR_NONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lec  <= ERR_NOCHG;
            dlec <= ERR_NOCHG;
        end else begin
            if (ev && !dphase)
                lec <= ev_code;
            else if (rd)
                lec <= ERR_NOCHG;
            if (ev && dphase)
                dlec <= ev_code;
        end
    end

    AST_LEC_READ_RELOAD: assert property (@(posedge clk) disable iff (rst)
        (rd && !ok && !err) |=> lec == ERR_NOCHG); // R3
    AST_DLEC_READ_KEEP: assert property (@(posedge clk) disable iff (rst)
        (rd && !ok && !err) |=> $stable(dlec)); // R3
    AST_LEC_OK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ok && !err && !dphase) |=> lec == ERR_NONE); // R4
    AST_DPHASE_KEEP_LEC: assert property (@(posedge clk) disable iff (rst)
        ((ok || err) && dphase && !rd) |=> $stable(lec)); // R5
    AST_DLEC_OK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ok && !err && dphase) |=> dlec == ERR_NONE); // R5
    AST_FIXED_STUFF_FORM: assert property (@(posedge clk) disable iff (rst)
        (err && !dphase && err_code == 3'd1 && fixed_stuff) |=> lec == ERR_FORM); // R6
    AST_ERR_BEATS_READ: assert property (@(posedge clk) disable iff (rst)
        (err && rd && !dphase && err_code == 3'd6) |=> lec == ERR_CRC); // R11
    AST_ERR_BEATS_OK: assert property (@(posedge clk) disable iff (rst)
        (err && ok && !dphase && err_code == 3'd3) |=> lec == ERR_ACK); // R12

endmodule

// File: rtl/can_psr_flags.sv
module can_psr_flags
    import can_psr_pkg::*;
#(
    parameter int N = NUM_FLAGS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         rd,
    input  logic [N-1:0] set,
    input  logic [N-1:0] val,
    output logic [N-1:0] q
);

    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                q[i] <= 1'b0;
            else if (set[i])
                q[i] <= val[i];
            else if (rd)
                q[i] <= 1'b0;
        end

        AST_FLAG_EVENT_LOADS: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> q[i] == $past(val[i])); // R7
        AST_FLAG_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
            (rd && !set[i]) |=> !q[i]); // R10
        AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (rst)
            (!rd && !set[i]) |=> $stable(q[i])); // R10
    end

endmodule

// File: rtl/can_psr.sv
module can_psr
    import can_psr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              host_rd,
    output logic [REG_W-1:0]  rd_data,
    input  logic              frame_ok,
    input  logic              err_evt,
    input  logic [CODE_W-1:0] err_type,
    input  logic              in_data_phase,
    input  logic              crc_fixed_stuff,
    input  logic              fd_rx,
    input  logic              fd_rx_brs,
    input  logic              fd_rx_esi,
    input  logic              proto_exc,
    input  logic [ACT_W-1:0]  activity,
    input  logic              bus_off,
    input  logic              err_warn,
    input  logic              err_passive,
    input  logic [TDC_W-1:0]  tdc_value
);

    err_code_e            lec;
    err_code_e            dlec;
    logic [NUM_FLAGS-1:0] fl_set;
    logic [NUM_FLAGS-1:0] fl_val;
    logic [NUM_FLAGS-1:0] fl_q;
    psr_t                 psr;

    can_psr_errlog u_errlog (
        .clk         (clk),
        .rst         (rst),
        .rd          (host_rd),
        .ok          (frame_ok),
        .err         (err_evt),
        .err_code    (err_type),
        .dphase      (in_data_phase),
        .fixed_stuff (crc_fixed_stuff),
        .lec         (lec),
        .dlec        (dlec)
    );

    always_comb begin
        fl_set          = '0;
        fl_val          = '0;
        fl_set[FL_PXE]  = proto_exc;
        fl_val[FL_PXE]  = 1'b1;
        fl_set[FL_RFDF] = fd_rx;
        fl_val[FL_RFDF] = 1'b1;
        fl_set[FL_RBRS] = fd_rx;
        fl_val[FL_RBRS] = fd_rx_brs;
        fl_set[FL_RESI] = fd_rx;
        fl_val[FL_RESI] = fd_rx_esi;
    end

    can_psr_flags #(.N(NUM_FLAGS)) u_flags (
        .clk (clk),
        .rst (rst),
        .rd  (host_rd),
        .set (fl_set),
        .val (fl_val),
        .q   (fl_q)
    );

    always_comb begin
        psr         = '0;
        psr.tdc     = tdc_value;
        psr.flags   = fl_q;
        psr.dlec    = dlec;
        psr.bo      = bus_off;
        psr.ew      = err_warn;
        psr.ep      = err_passive;
        psr.act     = act_e'(activity);
        psr.lec     = lec;
        rd_data     = psr;
    end

    AST_RFDF_ON_FD: assert property (@(posedge clk) disable iff (rst)
        fd_rx |=> rd_data[13]); // R7
    AST_PXE_ON_EXC: assert property (@(posedge clk) disable iff (rst)
        proto_exc |=> rd_data[14]); // R10

endmodule

// File: tb/can_psr_tb_top.sv
`timescale 1ns/1ps
module can_psr_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        host_rd, frame_ok, err_evt, in_data_phase, crc_fixed_stuff;
    logic [2:0]  err_type;
    logic        fd_rx, fd_rx_brs, fd_rx_esi, proto_exc;
    logic [1:0]  activity;
    logic        bus_off, err_warn, err_passive;
    logic [6:0]  tdc_value;
    logic [31:0] rd_data;

    int checks   = 0;
    int failures = 0;

    always #2.5 clk = ~clk;

    can_psr dut_i (
        .clk(clk), .rst(rst), .host_rd(host_rd), .rd_data(rd_data),
        .frame_ok(frame_ok), .err_evt(err_evt), .err_type(err_type),
        .in_data_phase(in_data_phase), .crc_fixed_stuff(crc_fixed_stuff),
        .fd_rx(fd_rx), .fd_rx_brs(fd_rx_brs), .fd_rx_esi(fd_rx_esi),
        .proto_exc(proto_exc), .activity(activity), .bus_off(bus_off),
        .err_warn(err_warn), .err_passive(err_passive), .tdc_value(tdc_value)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic idle_inputs();
        host_rd = 0; frame_ok = 0; err_evt = 0; err_type = 0;
        in_data_phase = 0; crc_fixed_stuff = 0; fd_rx = 0; fd_rx_brs = 0;
        fd_rx_esi = 0; proto_exc = 0; activity = 0; bus_off = 0;
        err_warn = 0; err_passive = 0; tdc_value = 0;
    endtask

    task automatic do_read();
        host_rd = 1; step(); host_rd = 0;
    endtask

    task automatic do_err(input logic [2:0] t, input logic dp, input logic fx);
        err_evt = 1; err_type = t; in_data_phase = dp; crc_fixed_stuff = fx;
        step();
        err_evt = 0; err_type = 0; in_data_phase = 0; crc_fixed_stuff = 0;
    endtask

    task automatic do_ok(input logic dp);
        frame_ok = 1; in_data_phase = dp; step();
        frame_ok = 0; in_data_phase = 0;
    endtask

    task automatic t_reset();
        check("R2 reset word", rd_data, 32'h0000_0707);
    endtask

    task automatic t_arb_codes();
        for (int c = 1; c <= 6; c++) begin
            do_err(3'(c), 1'b0, 1'b0);
            check("R1 lec code", {29'd0, rd_data[2:0]}, 32'(c));
        end
        check("R1 dlec untouched", {29'd0, rd_data[10:8]}, 32'd7);
    endtask

    task automatic t_read_reload();
        do_err(3'd4, 1'b0, 1'b0);
        do_read();
        check("R3 lec reload", {29'd0, rd_data[2:0]}, 32'd7);
        do_err(3'd5, 1'b1, 1'b0);
        do_read();
        check("R3 dlec kept on read", {29'd0, rd_data[10:8]}, 32'd5);
    endtask

    task automatic t_ok_clear();
        do_err(3'd3, 1'b0, 1'b0);
        do_ok(1'b0);
        check("R4 ok clears lec", {29'd0, rd_data[2:0]}, 32'd0);
    endtask

    task automatic t_dphase();
        do_err(3'd2, 1'b0, 1'b0);
        do_err(3'd6, 1'b1, 1'b0);
        check("R5 dlec err", {29'd0, rd_data[10:8]}, 32'd6);
        check("R5 lec kept", {29'd0, rd_data[2:0]}, 32'd2);
        do_ok(1'b1);
        check("R5 dlec ok", {29'd0, rd_data[10:8]}, 32'd0);
        check("R5 lec kept after ok", {29'd0, rd_data[2:0]}, 32'd2);
    endtask

    task automatic t_fixed_stuff();
        do_err(3'd1, 1'b0, 1'b1);
        check("R6 fixed stuff as form", {29'd0, rd_data[2:0]}, 32'd2);
        do_err(3'd6, 1'b0, 1'b1);
        check("R6 other type kept", {29'd0, rd_data[2:0]}, 32'd6);
        do_err(3'd1, 1'b1, 1'b1);
        check("R6 data phase form", {29'd0, rd_data[10:8]}, 32'd2);
    endtask

    task automatic t_fd_rx();
        fd_rx = 1; fd_rx_brs = 1; fd_rx_esi = 0; step(); fd_rx = 0; fd_rx_brs = 0;
        check("R7 fd flags a", {29'd0, rd_data[13:11]}, 32'b110);
        fd_rx = 1; fd_rx_esi = 1; step(); fd_rx = 0; fd_rx_esi = 0;
        check("R7 fd flags b", {29'd0, rd_data[13:11]}, 32'b101);
    endtask

    task automatic t_flags_read();
        proto_exc = 1; step(); proto_exc = 0;
        check("R10 pxe set", {31'd0, rd_data[14]}, 32'd1);
        do_read();
        check("R10 read clears", {28'd0, rd_data[14:11]}, 32'd0);
        proto_exc = 1; fd_rx = 1; fd_rx_brs = 1; host_rd = 1; step();
        proto_exc = 0; fd_rx = 0; fd_rx_brs = 0; host_rd = 0;
        check("R10 set beats read", {28'd0, rd_data[14:11]}, 32'b1110);
        do_read();
        check("R10 cleared again", {28'd0, rd_data[14:11]}, 32'd0);
    endtask

    task automatic t_err_with_read();
        host_rd = 1; do_err(3'd6, 1'b0, 1'b0); host_rd = 0;
        check("R11 err beats read", {29'd0, rd_data[2:0]}, 32'd6);
    endtask

    task automatic t_err_with_ok();
        frame_ok = 1; do_err(3'd3, 1'b0, 1'b0); frame_ok = 0;
        check("R12 err beats ok", {29'd0, rd_data[2:0]}, 32'd3);
    endtask

    task automatic t_status();
        for (int a = 0; a < 4; a++) begin
            activity = 2'(a); #1;
            check("R8 activity", {30'd0, rd_data[4:3]}, 32'(a));
        end
        bus_off = 1; err_warn = 0; err_passive = 1; #1;
        check("R8 bo/ew/ep", {29'd0, rd_data[7:5]}, 32'b101);
        bus_off = 0; err_warn = 1; err_passive = 0; #1;
        check("R8 ew only", {29'd0, rd_data[7:5]}, 32'b010);
        tdc_value = 7'h7f; #1;
        check("R9 tdc max", {25'd0, rd_data[22:16]}, 32'h7f);
        tdc_value = 7'h55; #1;
        check("R9 tdc pattern", {25'd0, rd_data[22:16]}, 32'h55);
        check("R9 reserved zero", {22'd0, rd_data[31:23], rd_data[15]}, 32'd0);
        activity = 0; err_warn = 0; tdc_value = 0;
    endtask

    initial begin
        #(5.0 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        step(); step();
        rst = 0;
        t_reset();
        t_arb_codes();
        t_read_reload();
        t_ok_clear();
        t_dphase();
        t_fixed_stuff();
        t_fd_rx();
        t_flags_read();
        t_err_with_read();
        t_err_with_ok();
        t_status();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule